// File: doc/BRIEF.md
# UART Channel Diagnostic Mode Router

This block sits between one UART transmitter core, one receiver core, the two serial pins and the CPU-facing side of a channel. A 2-bit mode input selects one of four routings:

- **Normal:** every path is passed straight through.
- **Automatic echo:** the receive line is reclocked and retransmitted.
- **Local loopback:** the transmitter is turned back into the receiver.
- **Remote loopback:** incoming data is echoed and nothing is delivered to the CPU.

For each mode the block selects the serial data paths and the per-bit clock enables. It also masks the CPU-side status, write strobe and receive delivery. Mode changes act in the same cycle, including in the middle of a character. The one exception is leaving an echo mode while the stop bit is being re-sent. If the receiver has just sampled a stop bit and the transmitter is enabled, the echo routing is held for one full bit time of receive oversampling ticks. Only then does the new mode apply.

The shift engines, FIFOs and baud generation sit outside this block. The block sees them only as serial bits, tick strobes and status lines.

Top module: `uart_mode_router`

## Requirements
- R1: `mode_i` encodes 00 normal, 01 automatic echo, 10 local loopback and 11 remote loopback. A change of `mode_i` alters the routing combinationally in the same cycle, even within a character, unless the R7 hold is active.
- R2: In normal mode, the following signals pass straight through:
  - serial: `txd_o`=`core_txd_i` and `core_rxd_o`=`rxd_i`
  - ticks: `core_tx_tick_o`=`tx_tick_i` and `core_rx_tick_o`=`rx_tick_i`
  - CPU side: every status, write and receive output equals its input.
- R3: In automatic echo mode, `txd_o` is a register loaded from `rxd_i` on each clock edge where `rx_tick_i` is high, so it changes one cycle after such an edge. Also `core_tx_tick_o`=`rx_tick_i` and `core_rxd_o`=`rxd_i`.
- R4: In automatic echo mode, `tx_rdy_o`, `tx_emt_o` and `core_tx_wr_o` read 0. `rx_valid_o`, `rx_data_o` and `rx_err_o` pass through.
- R5: In local loopback mode:
  - `txd_o` is 1 and `core_rxd_o`=`core_txd_i`, so `rxd_i` has no effect on any output.
  - `core_rx_tick_o`=`tx_tick_i` and `core_tx_tick_o`=`tx_tick_i`.
  - The CPU paths pass through.
- R6: In remote loopback mode:
  - The serial echo and ticks behave as in R3.
  - `rx_valid_o`, `rx_data_o` and `rx_err_o` are forced to 0.
  - The transmitter status and write paths pass through.
- R7: A hold starts when `rx_stop_seen_i` and `tx_en_i` are both high on a clock edge while the effective mode is 01 or 11. From that edge the routing stays in that echo mode for OVS rising `rx_tick_i` edges, whatever `mode_i` does. With `tx_en_i` low, no hold starts.
- R8: In both echo modes, a received break (`rxd_i` low for many ticks) appears on `txd_o` as a continuous low until the line returns high.
- R9: After reset the echo register reads 1 and no hold is active. Entering an echo mode before any receive tick therefore shows `txd_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Channel mode select |
| tx_en_i | input | 1 | Transmitter enabled |
| rxd_i | input | 1 | Receive serial pin |
| txd_o | output | 1 | Transmit serial pin |
| core_txd_i | input | 1 | Serial output of transmitter core |
| core_rxd_o | output | 1 | Serial input to receiver core |
| tx_tick_i | input | 1 | Transmit bit-clock enable |
| rx_tick_i | input | 1 | Receive bit-clock enable |
| core_tx_tick_o | output | 1 | Clock enable to transmitter core |
| core_rx_tick_o | output | 1 | Clock enable to receiver core |
| rx_stop_seen_i | input | 1 | Receiver sampled a stop bit (pulse) |
| cpu_tx_wr_i | input | 1 | CPU write to transmitter |
| core_tx_wr_o | output | 1 | Gated write to transmitter core |
| tx_rdy_i | input | 1 | Transmitter ready from core |
| tx_rdy_o | output | 1 | Transmitter ready to CPU |
| tx_emt_i | input | 1 | Transmitter empty from core |
| tx_emt_o | output | 1 | Transmitter empty to CPU |
| rx_valid_i | input | 1 | Received character valid from core |
| rx_valid_o | output | 1 | Received character valid to CPU |
| rx_data_i | input | DATA_W | Received character from core |
| rx_data_o | output | DATA_W | Received character to CPU |
| rx_err_i | input | ERR_W | Receive error flags from core |
| rx_err_o | output | ERR_W | Receive error flags to CPU |

## Verification
Most outputs are combinational in `mode_i` and the inputs. The bench drives each vector on the falling edge and compares all outputs 1 ns later, in the same half cycle.

The echo bit is the only registered data path. The bench's model loads it on the rising edge where `rx_tick_i` is high, and compares `txd_o` at the following falling edge.

The exit hold is timed in receive ticks. Each tick is held high across exactly one rising edge. `txd_o` is checked after the OVS-1th tick (hold still active) and again after the OVS-th tick (new mode in force).

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_ECHO   = 2'b01,
    MODE_LLOOP  = 2'b10,
    MODE_RLOOP  = 2'b11
  } route_mode_e;

  function automatic logic is_echo(input route_mode_e m);
    return (m == MODE_ECHO) || (m == MODE_RLOOP);
  endfunction
endpackage

// File: rtl/route_echo_reg.sv
module route_echo_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_tick_i,
  input  logic rxd_i,
  output logic echo_o
);
  logic echo_q;
  // reclock received line on the receive bit clock; idles at mark
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        echo_q <= 1'b1;
    else if (rx_tick_i) echo_q <= rxd_i;
  end
  assign echo_o = echo_q;
endmodule

// File: rtl/route_exit_hold.sv
module route_exit_hold
  import uart_route_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  route_mode_e mode_i,
  input  logic        tx_en_i,
  input  logic        rx_stop_seen_i,
  input  logic        rx_tick_i,
  output route_mode_e eff_mode_o,
  output logic        hold_o
);
  localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  logic             hold_q;
  route_mode_e      held_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      held_q <= MODE_NORMAL;
      cnt_q  <= '0;
    end else if (!hold_q) begin
      if (rx_stop_seen_i && tx_en_i && is_echo(mode_i)) begin
        hold_q <= 1'b1;
        held_q <= mode_i;
        cnt_q  <= '0;
      end
    end else if (rx_tick_i) begin
      if (cnt_q == LAST) hold_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign eff_mode_o = hold_q ? held_q : mode_i;
  assign hold_o     = hold_q;
endmodule

// File: rtl/route_serial_mux.sv
module route_serial_mux
  import uart_route_pkg::*;
(
  input  route_mode_e mode_i,
  input  logic        rxd_i,
  input  logic        core_txd_i,
  input  logic        echo_i,
  input  logic        tx_tick_i,
  input  logic        rx_tick_i,
  output logic        txd_o,
  output logic        core_rxd_o,
  output logic        core_tx_tick_o,
  output logic        core_rx_tick_o
);
  always_comb begin
    txd_o          = core_txd_i;
    core_rxd_o     = rxd_i;
    core_tx_tick_o = tx_tick_i;
    core_rx_tick_o = rx_tick_i;
    unique case (mode_i)
      MODE_NORMAL: ;
      MODE_ECHO, MODE_RLOOP: begin
        txd_o          = echo_i;
        core_tx_tick_o = rx_tick_i;
      end
      MODE_LLOOP: begin
        txd_o          = 1'b1;
        core_rxd_o     = core_txd_i;
        core_rx_tick_o = tx_tick_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/route_cpu_gate.sv
module route_cpu_gate
  import uart_route_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3
) (
  input  route_mode_e       mode_i,
  input  logic              cpu_tx_wr_i,
  input  logic              tx_rdy_i,
  input  logic              tx_emt_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [ERR_W-1:0]  rx_err_i,
  output logic              core_tx_wr_o,
  output logic              tx_rdy_o,
  output logic              tx_emt_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [ERR_W-1:0]  rx_err_o
);
  logic tx_blk, rx_blk;
  assign tx_blk = (mode_i == MODE_ECHO);
  assign rx_blk = (mode_i == MODE_RLOOP);

  assign core_tx_wr_o = cpu_tx_wr_i & ~tx_blk;
  assign tx_rdy_o     = tx_rdy_i    & ~tx_blk;
  assign tx_emt_o     = tx_emt_i    & ~tx_blk;
  assign rx_valid_o   = rx_valid_i  & ~rx_blk;
  assign rx_data_o    = rx_blk ? '0 : rx_data_i;
  assign rx_err_o     = rx_blk ? '0 : rx_err_i;
endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
  import uart_route_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              tx_en_i,
  input  logic              rxd_i,
  output logic              txd_o,
  input  logic              core_txd_i,
  output logic              core_rxd_o,
  input  logic              tx_tick_i,
  input  logic              rx_tick_i,
  output logic              core_tx_tick_o,
  output logic              core_rx_tick_o,
  input  logic              rx_stop_seen_i,
  input  logic              cpu_tx_wr_i,
  output logic              core_tx_wr_o,
  input  logic              tx_rdy_i,
  output logic              tx_rdy_o,
  input  logic              tx_emt_i,
  output logic              tx_emt_o,
  input  logic              rx_valid_i,
  output logic              rx_valid_o,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic [ERR_W-1:0]  rx_err_i,
  output logic [ERR_W-1:0]  rx_err_o
);
  route_mode_e eff_mode;
  logic        hold_w;
  logic        echo_w;

  route_exit_hold #(.OVS(OVS)) i_hold (
    .clk_i, .rst_ni,
    .mode_i         (route_mode_e'(mode_i)),
    .tx_en_i,
    .rx_stop_seen_i,
    .rx_tick_i,
    .eff_mode_o     (eff_mode),
    .hold_o         (hold_w)
  );

  route_echo_reg i_echo (
    .clk_i, .rst_ni, .rx_tick_i, .rxd_i,
    .echo_o (echo_w)
  );

  route_serial_mux i_ser (
    .mode_i (eff_mode),
    .rxd_i, .core_txd_i,
    .echo_i (echo_w),
    .tx_tick_i, .rx_tick_i,
    .txd_o, .core_rxd_o, .core_tx_tick_o, .core_rx_tick_o
  );

  route_cpu_gate #(.DATA_W(DATA_W), .ERR_W(ERR_W)) i_cpu (
    .mode_i (eff_mode),
    .cpu_tx_wr_i, .tx_rdy_i, .tx_emt_i, .rx_valid_i, .rx_data_i, .rx_err_i,
    .core_tx_wr_o, .tx_rdy_o, .tx_emt_o, .rx_valid_o, .rx_data_o, .rx_err_o
  );
endmodule

// File: rtl/uart_mode_router_chk.sv
module uart_mode_router_chk #(
  parameter int ERR_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       eff_mode,
  input logic             hold_w,
  input logic             rx_stop_seen_i,
  input logic             tx_en_i,
  input logic             rx_tick_i,
  input logic             rxd_i,
  input logic             core_txd_i,
  input logic             txd_o,
  input logic             core_rxd_o,
  input logic             tx_rdy_o,
  input logic             core_tx_wr_o,
  input logic             rx_valid_o,
  input logic [ERR_W-1:0] rx_err_o
);
  p_normal_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_mode == 2'b00 |-> (txd_o == core_txd_i) && (core_rxd_o == rxd_i));

  p_reclock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_tick_i && eff_mode[0]) |=> (!eff_mode[0] || txd_o == $past(rxd_i)));

  p_echo_tx_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_mode == 2'b01 |-> !tx_rdy_o && !core_tx_wr_o);

  p_local_loop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_mode == 2'b10 |-> txd_o && (core_rxd_o == core_txd_i));

  p_remote_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_mode == 2'b11 |-> !rx_valid_o && (rx_err_o == '0));

  p_hold_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_w) |-> $past(rx_stop_seen_i && tx_en_i));
endmodule

bind uart_mode_router uart_mode_router_chk #(.ERR_W(ERR_W)) i_chk (
  .clk_i, .rst_ni, .eff_mode, .hold_w, .rx_stop_seen_i, .tx_en_i, .rx_tick_i,
  .rxd_i, .core_txd_i, .txd_o, .core_rxd_o, .tx_rdy_o, .core_tx_wr_o,
  .rx_valid_o, .rx_err_o
);

// File: tb/test_uart_mode_router.sv
module test_uart_mode_router;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 3;
  localparam int OVS    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]        mode = 2'b00;
  logic              tx_en = 0, rxd = 1, core_txd = 1, tx_tick = 0, rx_tick = 0;
  logic              rx_stop = 0, cpu_wr = 0, tx_rdy = 0, tx_emt = 0, rx_valid = 0;
  logic [DATA_W-1:0] rx_data = '0;
  logic [ERR_W-1:0]  rx_err = '0;
  logic              txd, core_rxd, core_tx_tick, core_rx_tick, core_tx_wr;
  logic              tx_rdy_q, tx_emt_q, rx_valid_q;
  logic [DATA_W-1:0] rx_data_q;
  logic [ERR_W-1:0]  rx_err_q;

  int n_chk = 0, n_fail = 0;
  logic exp_echo;

  uart_mode_router #(.DATA_W(DATA_W), .ERR_W(ERR_W), .OVS(OVS)) i_uart_mode_router (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .tx_en_i(tx_en),
    .rxd_i(rxd), .txd_o(txd), .core_txd_i(core_txd), .core_rxd_o(core_rxd),
    .tx_tick_i(tx_tick), .rx_tick_i(rx_tick),
    .core_tx_tick_o(core_tx_tick), .core_rx_tick_o(core_rx_tick),
    .rx_stop_seen_i(rx_stop), .cpu_tx_wr_i(cpu_wr), .core_tx_wr_o(core_tx_wr),
    .tx_rdy_i(tx_rdy), .tx_rdy_o(tx_rdy_q), .tx_emt_i(tx_emt), .tx_emt_o(tx_emt_q),
    .rx_valid_i(rx_valid), .rx_valid_o(rx_valid_q),
    .rx_data_i(rx_data), .rx_data_o(rx_data_q), .rx_err_i(rx_err), .rx_err_o(rx_err_q)
  );

  // requirement model of the echo bit (R3)
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) exp_echo <= 1'b1;
    else if (rx_tick) exp_echo <= rxd;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // full output vector against the per-mode requirements
  task automatic check_all(input string req, input logic [1:0] m);
    logic [31:0] got, exp;
    logic e_txd, e_crxd, e_crt, e_ctt, tblk, rblk;
    e_txd  = (m == 2'b00) ? core_txd : (m == 2'b10) ? 1'b1 : exp_echo;
    e_crxd = (m == 2'b10) ? core_txd : rxd;
    e_crt  = (m == 2'b10) ? tx_tick : rx_tick;
    e_ctt  = m[0] ? rx_tick : tx_tick;
    tblk   = (m == 2'b01);
    rblk   = (m == 2'b11);
    got = {13'd0, txd, core_rxd, core_rx_tick, core_tx_tick, tx_rdy_q, tx_emt_q,
           core_tx_wr, rx_valid_q, rx_data_q, rx_err_q};
    exp = {13'd0, e_txd, e_crxd, e_crt, e_ctt, tx_rdy & ~tblk, tx_emt & ~tblk,
           cpu_wr & ~tblk, rx_valid & ~rblk, rblk ? 8'd0 : rx_data,
           rblk ? 3'd0 : rx_err};
    check(req, got, exp);
  endtask

  task automatic one_tick;
    @(negedge clk) rx_tick = 1'b1;
    @(negedge clk) rx_tick = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state, echo idles high, normal routing
    @(negedge clk) core_txd = 0; #1;
    check("R9 normal after reset", txd, 0);
    mode = 2'b01; #1;
    check("R9 echo reg idle high", txd, 1);
    mode = 2'b11; #1;
    check("R9 remote echo idle high", txd, 1);

    // R2 R3 R4 R5 R6: sweep every mode over every input pattern
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        mode = 2'(m);
        {rxd, core_txd, tx_tick, rx_tick, tx_rdy, tx_emt, rx_valid, cpu_wr} = 8'(p);
        rx_data = 8'(p * 37 + m);
        rx_err  = 3'(p + m);
        #1;
        case (m)
          0: check_all("R2 normal sweep", 2'(m));
          1: check_all("R3 R4 echo sweep", 2'(m));
          2: check_all("R5 local loop sweep", 2'(m));
          default: check_all("R6 remote sweep", 2'(m));
        endcase
      end

    // R5: rxd ignored in local loop
    @(negedge clk) mode = 2'b10; core_txd = 0; rx_tick = 0; tx_tick = 0; rxd = 0; #1;
    check("R5 rxd ignored low", {txd, core_rxd}, 2'b10);
    rxd = 1; #1;
    check("R5 rxd ignored high", {txd, core_rxd}, 2'b10);

    // R1: mode switched at varying points inside a character
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      rx_tick  = (k % 2) == 0;
      tx_tick  = (k % 3) == 0;
      rxd      = ((k / 4) % 2) == 1;
      core_txd = ((k / 3) % 2) == 0;
      tx_rdy = 1; rx_valid = 1; cpu_wr = k[0];
      if (k % 5 == 2) mode = mode + 2'd1;
      #1;
      check_all("R1 mid-character switch", mode);
    end
    rx_tick = 0; tx_tick = 0;

    // R8: break passes through echo, then line recovers
    @(negedge clk) mode = 2'b01; rxd = 0;
    repeat (3) one_tick();
    for (int k = 0; k < 40; k++) begin
      one_tick();
      if (k % 10 == 0) check("R8 break held low echo", txd, 0);
    end
    mode = 2'b11; #1;
    check("R8 break held low remote", txd, 0);
    @(negedge clk) rxd = 1;
    one_tick();
    check("R8 line returns to mark", txd, 1);

    // R7: deferred exit from echo while stop bit is re-sent
    @(negedge clk) mode = 2'b01; tx_en = 1; rxd = 1;
    one_tick();
    @(negedge clk) rx_stop = 1;
    @(negedge clk) rx_stop = 0; mode = 2'b00; core_txd = 0; tx_rdy = 1; #1;
    check("R7 hold keeps echo txd", txd, 1);
    check("R7 hold keeps echo status mask", tx_rdy_q, 0);
    for (int k = 0; k < OVS - 1; k++) one_tick();
    check("R7 still held before last tick", txd, 1);
    one_tick();
    check("R7 released after full bit", txd, 0);
    check("R7 status restored", tx_rdy_q, 1);

    // R7: remote loop hold masks receive delivery until release
    @(negedge clk) mode = 2'b11; rx_valid = 1;
    @(negedge clk) rx_stop = 1;
    @(negedge clk) rx_stop = 0; mode = 2'b00; #1;
    check("R7 remote hold masks rx_valid", rx_valid_q, 0);
    for (int k = 0; k < OVS; k++) one_tick();
    check("R7 remote release rx_valid", rx_valid_q, 1);

    // R7: transmitter disabled means immediate exit
    @(negedge clk) mode = 2'b01; tx_en = 0;
    @(negedge clk) rx_stop = 1;
    @(negedge clk) rx_stop = 0; mode = 2'b00; core_txd = 0; #1;
    check("R7 no hold without tx enable", txd, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule